// File: doc/BRIEF.md
# Block Protection Tuple Generator

This block sits in the write path of a storage controller and stamps an integrity tuple into the metadata of every fixed-size logical block. One byte stream enters on a valid/ready interface. For each block it carries the data bytes followed by the metadata bytes. The data bytes are consumed and hashed. Only the metadata bytes leave the block, on a second valid/ready interface, with the tuple bytes overwritten by the generated guard, application tag and reference tag.

Two tuple layouts can be selected. The narrow layout is 8 bytes: a CRC16 guard, a 16-bit application tag and a 32-bit reference tag. The wide layout is 16 bytes: a CRC64 guard, the 16-bit application tag and a 48-bit reference tag. The tuple sits either at the head or at the tail of each block's metadata. When it sits at the tail, the metadata bytes in front of it are also covered by the guard.

A zero-fill mode stamps tuples for blocks that are known to be all zeros. In this mode no data phase takes place, and every metadata position is produced from one input token. A command strobe loads the configuration state, and the block then runs block after block until the next strobe.

Top module: `ptg_top`

## Requirements
- R1: After reset and before the first `cmdStart`, `inReady`, `outValid` and `blockDone` are all low.
- R2: Outside zero-fill mode, each block begins with `cfgBlkBytes` data bytes. These are accepted with `inReady` high and produce no output, so `outValid` stays low during them.
- R3: Narrow layout (`cfgWideGuard`=0). The tuple is 8 bytes, each field sent most significant byte first, in this order: tuple bytes 0-1 are the CRC16 guard, bytes 2-3 are `cfgAppTag`, and bytes 4-7 are the low 32 bits of the reference tag. The CRC16 uses polynomial 0x8BB7, is not reflected and starts at zero.
- R4: Wide layout (`cfgWideGuard`=1). The tuple is 16 bytes, each field sent most significant byte first, in this order: bytes 0-7 are the guard, bytes 8-9 are `cfgAppTag`, and bytes 10-15 are the 48-bit reference tag. The guard is a reflected CRC64 with polynomial 0x9A6C9329AC4BC9B5, started at all ones and inverted at the end.
- R5: With `cfgTupleFirst`=1 the tuple occupies metadata bytes 0 up to (tuple size − 1). Otherwise it starts at byte `cfgMetaBytes` − tuple size.
- R6: The guard covers the block's data bytes. When the tuple is at the tail, it also covers the metadata bytes before the tuple, in stream order. Metadata bytes after a head tuple are not covered.
- R7: Outside zero-fill mode, metadata bytes outside the tuple leave the block unchanged.
- R8: The reference tag is loaded from `cfgRefStart` on `cmdStart`. It advances by one after each block when `cfgPiType` is not 3, and stays constant when `cfgPiType` is 3.
- R9: With `cfgZeroFill`=1 there is no data phase, and the input byte values are ignored. Non-tuple bytes are emitted as 0x00. The guard is 0x0000 in the narrow layout and 0x6482D367EB22B64E in the wide layout.
- R10: `blockDone` is high for exactly one cycle, the cycle after the last metadata byte of a block is transferred.
- R11: During the metadata phase a byte moves only when both `inValid` and `outReady` are high. While `outReady` is low, `inReady` is low and no byte is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cmdStart | input | 1 | Loads the reference tag and restarts at the first byte of a block |
| cfgBlkBytes | input | BLK_W | Data bytes per block |
| cfgMetaBytes | input | META_W | Metadata bytes per block |
| cfgTupleFirst | input | 1 | 1: tuple at the head of the metadata; 0: tuple at the tail |
| cfgWideGuard | input | 1 | 0: narrow 8-byte tuple; 1: wide 16-byte tuple |
| cfgPiType | input | 2 | Protection type; 3 keeps the reference tag fixed |
| cfgZeroFill | input | 1 | Zero-fill mode |
| cfgAppTag | input | 16 | Application tag |
| cfgRefStart | input | 48 | Starting reference tag |
| inValid | input | 1 | Input byte valid |
| inReady | output | 1 | Input byte accepted |
| inData | input | 8 | Input byte: data, then metadata |
| outValid | output | 1 | Output metadata byte valid |
| outReady | input | 1 | Downstream ready |
| outData | output | 8 | Output metadata byte |
| blockDone | output | 1 | One-cycle pulse after each block |

## Verification
The assertions assume that the configuration inputs stay constant between two `cmdStart` strobes, that `cfgMetaBytes` is at least the tuple size, and that `cfgBlkBytes` is at least one. The bench changes the configuration only while the block is idle between strobes, and it picks only sizes within these limits. Its stimulus holds `inValid` high until a byte is accepted, so the stalled handshakes exercise the backpressure path without changing the stream.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

  localparam logic [15:0] CRC16_POLY = 16'h8BB7;
  localparam logic [63:0] CRC64_POLY = 64'h9A6C9329AC4BC9B5;
  localparam logic [63:0] ZERO_GUARD64 = 64'h6482D367EB22B64E;

  typedef struct packed {
    logic       start;
    logic       hashEn;
    logic       blockEnd;
    logic       inTuple;
    logic [3:0] tupleIdx;
  } ptgStrobes_t;

  function automatic logic [15:0] crc16Step(input logic [15:0] crc, input logic [7:0] b);
    logic [15:0] c;
    c = crc ^ {b, 8'h00};
    for (int i = 0; i < 8; i++) c = c[15] ? ((c << 1) ^ CRC16_POLY) : (c << 1);
    return c;
  endfunction

  function automatic logic [63:0] crc64Step(input logic [63:0] crc, input logic [7:0] b);
    logic [63:0] c;
    c = crc ^ {56'd0, b};
    for (int i = 0; i < 8; i++) c = c[0] ? ((c >> 1) ^ CRC64_POLY) : (c >> 1);
    return c;
  endfunction

endpackage

// File: rtl/ptg_ctrl.sv
module ptg_ctrl
  import ptg_pkg::*;
#(
  parameter int BLK_W  = 16,
  parameter int META_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic [BLK_W-1:0]  cfgBlkBytes,
  input  logic [META_W-1:0] cfgMetaBytes,
  input  logic              cfgTupleFirst,
  input  logic              cfgWideGuard,
  input  logic              cfgZeroFill,
  input  logic              inValid,
  input  logic              outReady,
  output logic              inReady,
  output logic              outValid,
  output logic              blockDone,
  output ptgStrobes_t       strb
);

  localparam int CNT_W = (BLK_W > META_W) ? BLK_W : META_W;

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_META} phase_t;

  phase_t     phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] tupleSize;
  logic [CNT_W-1:0] tupleBase;
  logic [CNT_W-1:0] tupleOff;
  logic       fire;
  logic       lastData;
  logic       lastMeta;
  logic       inMeta;

  always_comb begin
    tupleSize = cfgWideGuard ? CNT_W'(16) : CNT_W'(8);
    tupleBase = cfgTupleFirst ? '0 : (CNT_W'(cfgMetaBytes) - tupleSize);
    tupleOff  = cnt - tupleBase;
    inMeta    = (phase == ST_META);
    inReady   = (phase == ST_DATA) || (inMeta && outReady);
    outValid  = inMeta && inValid;
    fire      = inValid && inReady;
    lastData  = (cnt == CNT_W'(cfgBlkBytes) - CNT_W'(1));
    lastMeta  = (cnt == CNT_W'(cfgMetaBytes) - CNT_W'(1));

    strb.start    = cmdStart;
    strb.hashEn   = fire && ((phase == ST_DATA) ||
                             (inMeta && !cfgTupleFirst && (cnt < tupleBase)));
    strb.blockEnd = fire && inMeta && lastMeta;
    strb.inTuple  = inMeta && (cnt >= tupleBase) && (tupleOff < tupleSize);
    strb.tupleIdx = tupleOff[3:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= ST_IDLE;
      cnt       <= '0;
      blockDone <= 1'b0;
    end else begin
      blockDone <= strb.blockEnd;
      if (cmdStart) begin
        phase <= cfgZeroFill ? ST_META : ST_DATA;
        cnt   <= '0;
      end else if (fire) begin
        if (phase == ST_DATA) begin
          if (lastData) begin
            phase <= ST_META;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end else if (lastMeta) begin
          phase <= cfgZeroFill ? ST_META : ST_DATA;
          cnt   <= '0;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/ptg_datapath.sv
module ptg_datapath
  import ptg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ptgStrobes_t strb,
  input  logic        cfgWideGuard,
  input  logic        cfgZeroFill,
  input  logic [1:0]  cfgPiType,
  input  logic [15:0] cfgAppTag,
  input  logic [47:0] cfgRefStart,
  input  logic [7:0]  inData,
  output logic [7:0]  outData
);

  logic [15:0]  crc16;
  logic [63:0]  crc64;
  logic [47:0]  refTag;
  logic [15:0]  guard16;
  logic [63:0]  guard64;
  logic [127:0] tupleVec;
  logic [7:0]   tupleByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crc16  <= '0;
      crc64  <= '1;
      refTag <= '0;
    end else begin
      if (strb.start || strb.blockEnd) begin
        crc16 <= '0;
        crc64 <= '1;
      end else if (strb.hashEn) begin
        crc16 <= crc16Step(crc16, inData);
        crc64 <= crc64Step(crc64, inData);
      end
      if (strb.start) refTag <= cfgRefStart;
      else if (strb.blockEnd && (cfgPiType != 2'd3)) refTag <= refTag + 48'd1;
    end
  end

  always_comb begin
    guard16 = cfgZeroFill ? 16'h0000 : crc16;
    guard64 = cfgZeroFill ? ZERO_GUARD64 : ~crc64;
    if (cfgWideGuard) tupleVec = {guard64, cfgAppTag, refTag};
    else              tupleVec = {guard16, cfgAppTag, refTag[31:0], 64'd0};
    tupleByte = tupleVec[127 - 8 * strb.tupleIdx -: 8];
    if (strb.inTuple)    outData = tupleByte;
    else if (cfgZeroFill) outData = 8'h00;
    else                 outData = inData;
  end

endmodule

// File: rtl/ptg_top.sv
module ptg_top
  import ptg_pkg::*;
#(
  parameter int BLK_W  = 16,
  parameter int META_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic [BLK_W-1:0]  cfgBlkBytes,
  input  logic [META_W-1:0] cfgMetaBytes,
  input  logic              cfgTupleFirst,
  input  logic              cfgWideGuard,
  input  logic [1:0]        cfgPiType,
  input  logic              cfgZeroFill,
  input  logic [15:0]       cfgAppTag,
  input  logic [47:0]       cfgRefStart,
  input  logic              inValid,
  output logic              inReady,
  input  logic [7:0]        inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [7:0]        outData,
  output logic              blockDone
);

  ptgStrobes_t strb;

  ptg_ctrl #(.BLK_W(BLK_W), .META_W(META_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart),
    .cfgBlkBytes(cfgBlkBytes), .cfgMetaBytes(cfgMetaBytes),
    .cfgTupleFirst(cfgTupleFirst), .cfgWideGuard(cfgWideGuard),
    .cfgZeroFill(cfgZeroFill), .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .blockDone(blockDone), .strb(strb)
  );

  ptg_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgWideGuard(cfgWideGuard),
    .cfgZeroFill(cfgZeroFill), .cfgPiType(cfgPiType), .cfgAppTag(cfgAppTag),
    .cfgRefStart(cfgRefStart), .inData(inData), .outData(outData)
  );

endmodule

// File: rtl/ptg_checker.sv
module ptg_checker (
  input logic clk,
  input logic rstN,
  input logic cmdStart,
  input logic cfgZeroFill,
  input logic inValid,
  input logic inReady,
  input logic outValid,
  input logic outReady,
  input logic blockDone
);

  // R2: a block outside zero-fill opens with a silent data phase
  assert_data_silent_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart && !cfgZeroFill |=> !outValid);

  // R2: an output byte always stands for an input byte
  assert_out_follows_in_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> inValid);

  // R11: a stalled output holds the input
  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |-> !inReady);

  // R11: a metadata byte is accepted only when downstream takes it
  assert_accept_needs_ready_R11: assert property (@(posedge clk) disable iff (!rstN)
    outValid && inReady |-> outReady);

  // R10: the block-done strobe is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    blockDone |=> !blockDone);

endmodule

bind ptg_top ptg_checker u_chk (
  .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cfgZeroFill(cfgZeroFill),
  .inValid(inValid), .inReady(inReady), .outValid(outValid),
  .outReady(outReady), .blockDone(blockDone)
);

// File: tb/ptg_top_tb.sv
module ptg_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdStart = 1'b0;
  logic [15:0] cfgBlkBytes = 16'd16;
  logic [7:0]  cfgMetaBytes = 8'd8;
  logic        cfgTupleFirst = 1'b0;
  logic        cfgWideGuard = 1'b0;
  logic [1:0]  cfgPiType = 2'd1;
  logic        cfgZeroFill = 1'b0;
  logic [15:0] cfgAppTag = 16'h0;
  logic [47:0] cfgRefStart = 48'h0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [7:0]  inData = 8'h0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [7:0]  outData;
  logic        blockDone;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int badData;
  int badMeta;
  logic [7:0] lastGot;
  logic [7:0] lastExp;

  always #4 clk = ~clk;

  ptg_top u_dut (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cfgBlkBytes(cfgBlkBytes),
    .cfgMetaBytes(cfgMetaBytes), .cfgTupleFirst(cfgTupleFirst),
    .cfgWideGuard(cfgWideGuard), .cfgPiType(cfgPiType), .cfgZeroFill(cfgZeroFill),
    .cfgAppTag(cfgAppTag), .cfgRefStart(cfgRefStart), .inValid(inValid),
    .inReady(inReady), .inData(inData), .outValid(outValid), .outReady(outReady),
    .outData(outData), .blockDone(blockDone)
  );

  task automatic finishRun();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 50000", cycles);
      finishRun();
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bitwise reference models
  function automatic logic [15:0] ref16(input logic [15:0] c, input logic [7:0] b);
    logic fb;
    for (int i = 7; i >= 0; i--) begin
      fb = c[15] ^ b[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h8BB7;
    end
    return c;
  endfunction

  function automatic logic [63:0] ref64(input logic [63:0] c, input logic [7:0] b);
    logic fb;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ b[i];
      c = {1'b0, c[63:1]};
      if (fb) c = c ^ 64'h9A6C9329AC4BC9B5;
    end
    return c;
  endfunction

  function automatic logic [7:0] dataByte(input int b, input int i);
    return 8'((b * 37 + i * 11 + 7) & 255);
  endfunction

  function automatic logic [7:0] metaByte(input int b, input int j);
    return 8'((b * 5 + j * 3 + 8'h40) & 255);
  endfunction

  task automatic configure(input int blk, input int meta, input bit first, input bit wide,
                           input int ptype, input bit zero, input logic [15:0] app,
                           input logic [47:0] refv);
    @(negedge clk);
    cfgBlkBytes = 16'(blk);
    cfgMetaBytes = 8'(meta);
    cfgTupleFirst = first;
    cfgWideGuard = wide;
    cfgPiType = 2'(ptype);
    cfgZeroFill = zero;
    cfgAppTag = app;
    cfgRefStart = refv;
    cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] d, input bit meta, input logic [7:0] e, input bit stall);
    bit done = 0;
    int k = 0;
    while (!done) begin
      inValid = 1'b1;
      inData = d;
      outReady = !(stall && (k % 2 == 0));
      k++;
      #1;
      if (inReady) begin
        if (meta) begin
          if (!outValid || outData !== e) begin
            if (badMeta == 0) begin lastGot = outData; lastExp = e; end
            badMeta++;
          end
        end else if (outValid) badData++;
        done = 1;
      end
      @(negedge clk);
    end
    inValid = 1'b0;
    outReady = 1'b1;
  endtask

  task automatic runBlocks(input int nBlk, input bit stall, input string req);
    int blk = int'(cfgBlkBytes);
    int meta = int'(cfgMetaBytes);
    int tsz = cfgWideGuard ? 16 : 8;
    int base = cfgTupleFirst ? 0 : meta - tsz;
    for (int b = 0; b < nBlk; b++) begin
      logic [15:0] c16 = 16'h0;
      logic [63:0] c64 = '1;
      logic [47:0] r = cfgRefStart + ((cfgPiType != 2'd3) ? 48'(b) : 48'd0);
      logic [15:0] g16;
      logic [63:0] g64;
      logic [7:0] exp;
      int k;
      badData = 0;
      badMeta = 0;
      if (!cfgZeroFill) begin
        for (int i = 0; i < blk; i++) begin
          c16 = ref16(c16, dataByte(b, i));
          c64 = ref64(c64, dataByte(b, i));
          xfer(dataByte(b, i), 1'b0, 8'h00, stall);
        end
        for (int j = 0; j < base && !cfgTupleFirst; j++) begin
          c16 = ref16(c16, metaByte(b, j));
          c64 = ref64(c64, metaByte(b, j));
        end
      end
      g16 = cfgZeroFill ? 16'h0 : c16;
      g64 = cfgZeroFill ? 64'h6482D367EB22B64E : ~c64;
      for (int j = 0; j < meta; j++) begin
        k = j - base;
        if (k < 0 || k >= tsz) exp = cfgZeroFill ? 8'h00 : metaByte(b, j);
        else if (cfgWideGuard) begin
          if (k < 8) exp = g64[63 - 8 * k -: 8];
          else if (k < 10) exp = cfgAppTag[15 - 8 * (k - 8) -: 8];
          else exp = r[47 - 8 * (k - 10) -: 8];
        end else begin
          if (k < 2) exp = g16[15 - 8 * k -: 8];
          else if (k < 4) exp = cfgAppTag[15 - 8 * (k - 2) -: 8];
          else exp = r[31 - 8 * (k - 4) -: 8];
        end
        xfer(metaByte(b, j), 1'b1, exp, stall);
      end
      // R10: pulse in the cycle after the last metadata byte
      check(blockDone === 1'b1, "R10", "blockDone after block", 64'(blockDone), 64'd1);
      check(badData == 0, "R2", "output during data phase", 64'(badData), 64'd0);
      check(badMeta == 0, req, $sformatf("block %0d metadata byte", b), 64'(lastGot), 64'(lastExp));
      @(negedge clk);
      check(blockDone === 1'b0, "R10", "blockDone one cycle only", 64'(blockDone), 64'd0);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check(inReady === 1'b0, "R1", "inReady idle", 64'(inReady), 64'd0);
    check(outValid === 1'b0, "R1", "outValid idle", 64'(outValid), 64'd0);
    check(blockDone === 1'b0, "R1", "blockDone idle", 64'(blockDone), 64'd0);
  endtask

  task automatic testNarrowTail();
    // R3 R8: tuple fills the whole metadata, type 1 advances the tag
    configure(16, 8, 1'b0, 1'b0, 1, 1'b0, 16'hBEEF, 48'h1234_5678_9ABC);
    runBlocks(3, 1'b0, "R3");
  endtask

  task automatic testNarrowTailCover();
    // R6 R7 R11: tuple after 8 passthrough bytes that are hashed, with stalls
    configure(20, 16, 1'b0, 1'b0, 2, 1'b0, 16'h0A0B, 48'h0000_FFFF_FFFE);
    runBlocks(2, 1'b0, "R6");
    configure(20, 16, 1'b0, 1'b0, 1, 1'b0, 16'h1357, 48'h40);
    runBlocks(2, 1'b1, "R11");
  endtask

  task automatic testNarrowHead();
    // R5 R7: head tuple, trailing bytes pass through unhashed
    configure(12, 12, 1'b1, 1'b0, 1, 1'b0, 16'hC0DE, 48'h99);
    runBlocks(2, 1'b0, "R5");
    configure(12, 12, 1'b1, 1'b0, 1, 1'b0, 16'h0102, 48'h7);
    runBlocks(1, 1'b0, "R7");
  endtask

  task automatic testWide();
    // R4: wide tuple at the tail of 24 metadata bytes
    configure(32, 24, 1'b0, 1'b1, 2, 1'b0, 16'hFACE, 48'hABCD_EF01_2345);
    runBlocks(2, 1'b0, "R4");
    // R8: type 3 keeps the reference tag constant
    configure(16, 16, 1'b1, 1'b1, 3, 1'b0, 16'h5555, 48'h8000_0000_0001);
    runBlocks(3, 1'b0, "R8");
  endtask

  task automatic testZeroFill();
    // R9: no data phase, input values ignored, constant guards
    configure(16, 16, 1'b0, 1'b1, 1, 1'b1, 16'h1111, 48'h20);
    runBlocks(2, 1'b0, "R9");
    configure(16, 12, 1'b1, 1'b0, 1, 1'b1, 16'h2222, 48'h30);
    runBlocks(2, 1'b1, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testReset();
    testNarrowTail();
    testNarrowTailCover();
    testNarrowHead();
    testWide();
    testZeroFill();
    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule